// File: doc/BRIEF.md
# Memory-Mapped NAND Cycle Bridge

This block turns single host accesses into single asynchronous NAND flash bus cycles. The host sees one memory-mapped window split into four equal chip-select regions. Within a region, the offset picks the kind of NAND cycle: a data transfer, an address byte or a command byte. For each access the bridge makes exactly one strobed cycle. It lowers one chip enable, sets the latch-enable lines for the phase, and pulses either the write strobe or the read strobe. It then releases the chip enable before it can start another cycle.

Software builds a whole NAND operation from a series of these single cycles. The bridge never holds a chip enable across them. A ready/busy input from the flash gates command cycles. While the device is busy, only the reset and read-status commands are passed through. Any other command is held off by keeping host ready low until the device becomes ready. Accesses that decode to nothing finish at once and leave every NAND pin untouched.

Top module: `nand_cycle_bridge`

## Requirements
- R1: An access whose address bits [31:28] equal 0x7 is mapped to chip select n = address bits [27:26], so the regions start at 0x7000_0000, 0x7400_0000, 0x7800_0000 and 0x7C00_0000. Its cycle drives only `nand_ce_n[n]` low.
- R2: At no time is more than one bit of `nand_ce_n` low.
- R3: The region offset picks the phase. Offset 0x0000 gives a data cycle with ALE low and CLE low. Offset 0x2000 gives an address cycle with ALE high and CLE low. Offset 0x4000 gives a command cycle with ALE low and CLE high.
- R4: Command and address writes drive the byte from `host_wdata[7:0]` on `nand_dq_out[7:0]` and zero on `nand_dq_out[15:8]`. Data writes drive all 16 bits of `host_wdata`. `nand_dq_oe` is high for the whole of a write cycle.
- R5: After each cycle, every chip enable is high for at least one clock before any strobe falls again.
- R6: Chip enable, ALE and CLE are set and stable T_SETUP clocks before the strobe falls. The strobe stays low for T_ACTIVE clocks. Chip enable stays low for T_HOLD clocks after the strobe rises. The defaults are 2, 3 and 2.
- R7: A command write made while `nand_rb_n` is low, with a byte other than 0xFF or 0x70, is not accepted. `host_ready` stays low and no NAND pin moves until `nand_rb_n` goes high. The command then goes out.
- R8: The command bytes 0xFF (reset) and 0x70 (read status) are forwarded at once, even while `nand_rb_n` is low.
- R9: A data-phase read holds `nand_re_n` low for T_ACTIVE clocks. It samples `nand_dq_in` on the last clock before the strobe rises. It returns that value on `host_rdata` with a one-clock `host_rvalid` pulse.
- R10: Some accesses complete at once, and no chip enable or strobe moves. These are an access outside the window, an offset other than the three in R3, and a read at a command or address offset. Reads of this kind give one `host_rvalid` pulse with `host_rdata` = 0.
- R11: After reset, all chip enables and both strobes are high, ALE, CLE and `nand_dq_oe` are low, `host_rvalid` is low and `host_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Host access request, held until accepted |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 32 | Host byte address |
| host_wdata | input | 16 | Host write data |
| host_ready | output | 1 | Bridge can take the request this cycle |
| host_rvalid | output | 1 | One-clock read data valid pulse |
| host_rdata | output | 16 | Read data, qualified by host_rvalid |
| nand_ce_n | output | 4 | Active-low chip enables, one per region |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_dq_out | output | 16 | Data bus driven toward the flash |
| nand_dq_oe | output | 1 | Output enable for nand_dq_out |
| nand_dq_in | input | 16 | Data bus from the flash |
| nand_rb_n | input | 1 | Flash ready (1) / busy (0) |

## Verification
The bench plays the flash side. It moves `nand_dq_in` on every clock of a read strobe, so a bridge that samples early or late returns the wrong word. It counts the clocks of setup, strobe and hold, so an off-by-one counter shows up as a wrong count. It holds the device busy during an ordinary command and during the two exempt commands. A bridge with a loose busy gate would strobe the flash early. A bridge with a tight gate would stall reset or status until timeout. Back-to-back accesses, unmapped offsets, and reads at command offsets check two more faults: a chip enable held between cycles, and pin activity on an access that should be silent.

// File: rtl/ncb_pkg.sv
// Shared types of the NAND cycle bridge.
// Assumes: nothing beyond IEEE 1800-2017.
package ncb_pkg;

    // Kind of NAND bus cycle picked by the region offset
    typedef enum logic [1:0] {
        PH_DATA = 2'd0,
        PH_ADDR = 2'd1,
        PH_CMD  = 2'd2,
        PH_NONE = 2'd3
    } nand_phase_t;

    // Steps of one strobed bus cycle
    typedef enum logic [1:0] {
        CYC_IDLE   = 2'd0,
        CYC_SETUP  = 2'd1,
        CYC_ACTIVE = 2'd2,
        CYC_HOLD   = 2'd3
    } cyc_state_t;

endpackage

// File: rtl/ncb_addr_decode.sv
// Address decoder: finds the chip-select region and the NAND phase of a
// host address.
// Assumes: regions are 2**WIN_LSB bytes each and NCS is a power of two.
// The window base is aligned to NCS regions.
module ncb_addr_decode
    import ncb_pkg::*;
#(
    parameter int AW       = 32,
    parameter int WIN_LSB  = 26,
    parameter int NCS      = 4,
    parameter int CSW      = 2,
    parameter logic [AW-1:0] BASE = 32'h7000_0000,
    parameter int ALE_BIT  = 13,
    parameter int CLE_BIT  = 14
) (
    input  logic [AW-1:0]  addr,
    output logic           hit,
    output logic [CSW-1:0] cs,
    output nand_phase_t    phase
);
    localparam int TOP_LSB = WIN_LSB + CSW;
    localparam logic [WIN_LSB-1:0] SEL_M =
        (WIN_LSB'(1) << ALE_BIT) | (WIN_LSB'(1) << CLE_BIT);

    logic [WIN_LSB-1:0] off;

    // Compare the window bits, pick the region, then classify the offset
    always_comb begin
        hit = (addr[AW-1:TOP_LSB] == BASE[AW-1:TOP_LSB]);
        cs  = addr[TOP_LSB-1:WIN_LSB];
        off = addr[WIN_LSB-1:0];
        if ((off & ~SEL_M) != '0) begin
            phase = PH_NONE;
        end else begin
            case ({off[CLE_BIT], off[ALE_BIT]})
                2'b00:   phase = PH_DATA;
                2'b01:   phase = PH_ADDR;
                2'b10:   phase = PH_CMD;
                default: phase = PH_NONE;
            endcase
        end
    end

endmodule

// File: rtl/ncb_cycle_fsm.sv
// Cycle engine: makes one setup / strobe / hold NAND cycle for each start pulse.
// It captures read data on the last strobe clock and pulses rd_done one clock later.
// Assumes: start only while busy is low; T_SETUP, T_ACTIVE, T_HOLD >= 1.
module ncb_cycle_fsm
    import ncb_pkg::*;
#(
    parameter int NCS      = 4,
    parameter int CSW      = 2,
    parameter int DW       = 16,
    parameter int T_SETUP  = 2,
    parameter int T_ACTIVE = 3,
    parameter int T_HOLD   = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           start_wr,
    input  logic [CSW-1:0] start_cs,
    input  nand_phase_t    start_phase,
    input  logic [DW-1:0]  start_data,
    input  logic [DW-1:0]  dq_in,
    output logic           busy,
    output logic [NCS-1:0] ce_n,
    output logic           cle,
    output logic           ale,
    output logic           we_n,
    output logic           re_n,
    output logic [DW-1:0]  dq_out,
    output logic           dq_oe,
    output logic [DW-1:0]  rd_data,
    output logic           rd_done
);
    localparam int T_MAX = (T_SETUP > T_ACTIVE) ?
                           ((T_SETUP > T_HOLD) ? T_SETUP : T_HOLD) :
                           ((T_ACTIVE > T_HOLD) ? T_ACTIVE : T_HOLD);
    localparam int CW = $clog2(T_MAX + 1);

    cyc_state_t     state;
    logic [CW-1:0]  cnt;
    logic           wr_q;
    logic [CSW-1:0] cs_q;
    nand_phase_t    ph_q;
    logic [DW-1:0]  data_q;

    // Step through setup, strobe and hold, each counted down from its parameter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= CYC_IDLE;
            cnt     <= '0;
            wr_q    <= 1'b0;
            cs_q    <= '0;
            ph_q    <= PH_DATA;
            data_q  <= '0;
            rd_data <= '0;
            rd_done <= 1'b0;
        end else begin
            rd_done <= 1'b0;
            case (state)
                CYC_IDLE: if (start) begin
                    wr_q   <= start_wr;
                    cs_q   <= start_cs;
                    ph_q   <= start_phase;
                    data_q <= start_data;
                    cnt    <= CW'(T_SETUP - 1);
                    state  <= CYC_SETUP;
                end
                CYC_SETUP: if (cnt == '0) begin
                    cnt   <= CW'(T_ACTIVE - 1);
                    state <= CYC_ACTIVE;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                CYC_ACTIVE: if (cnt == '0) begin
                    if (!wr_q) begin
                        rd_data <= dq_in;
                        rd_done <= 1'b1;
                    end
                    cnt   <= CW'(T_HOLD - 1);
                    state <= CYC_HOLD;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                default: if (cnt == '0) begin
                    state <= CYC_IDLE;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            endcase
        end
    end

    // Decode the NAND pins from the registered step; idle releases every pin
    always_comb begin
        busy   = (state != CYC_IDLE);
        ce_n   = '1;
        if (busy) ce_n[cs_q] = 1'b0;
        cle    = busy && (ph_q == PH_CMD);
        ale    = busy && (ph_q == PH_ADDR);
        we_n   = !((state == CYC_ACTIVE) && wr_q);
        re_n   = !((state == CYC_ACTIVE) && !wr_q);
        dq_oe  = busy && wr_q;
        dq_out = data_q;
    end

    AST_SETUP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(we_n) || $fell(re_n)) |-> ($stable(ce_n) && $stable(cle) && $stable(ale))); // R6
    AST_CE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CYC_HOLD && cnt == '0) |=> (&ce_n)); // R5
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n)); // R6
    AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done); // R9

endmodule

// File: rtl/nand_cycle_bridge.sv
// Top of the NAND cycle bridge. It takes one host access at a time and
// decodes its region and phase. It gates busy-time commands, then runs
// one NAND cycle or completes the access silently.
// Assumes: the host holds req and its fields stable until accepted
// (req && ready at a clock edge).
module nand_cycle_bridge
    import ncb_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 16,
    parameter int NCS        = 4,
    parameter int WIN_LSB    = 26,
    parameter logic [AW-1:0] BASE = 32'h7000_0000,
    parameter int ALE_BIT    = 13,
    parameter int CLE_BIT    = 14,
    parameter int T_SETUP    = 2,
    parameter int T_ACTIVE   = 3,
    parameter int T_HOLD     = 2,
    parameter logic [7:0] CMD_RESET  = 8'hFF,
    parameter logic [7:0] CMD_STATUS = 8'h70
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           host_req,
    input  logic           host_wr,
    input  logic [AW-1:0]  host_addr,
    input  logic [DW-1:0]  host_wdata,
    output logic           host_ready,
    output logic           host_rvalid,
    output logic [DW-1:0]  host_rdata,
    output logic [NCS-1:0] nand_ce_n,
    output logic           nand_cle,
    output logic           nand_ale,
    output logic           nand_we_n,
    output logic           nand_re_n,
    output logic [DW-1:0]  nand_dq_out,
    output logic           nand_dq_oe,
    input  logic [DW-1:0]  nand_dq_in,
    input  logic           nand_rb_n
);
    localparam int CSW = $clog2(NCS);

    logic           hit;
    logic [CSW-1:0] cs;
    nand_phase_t    phase;
    logic           exempt;
    logic           blocked;
    logic           mapped_ok;
    logic           accept;
    logic [DW-1:0]  fmt_data;
    logic           fsm_busy;
    logic [DW-1:0]  fsm_rd_data;
    logic           fsm_rd_done;
    logic           quiet_rv;

    ncb_addr_decode #(
        .AW(AW), .WIN_LSB(WIN_LSB), .NCS(NCS), .CSW(CSW),
        .BASE(BASE), .ALE_BIT(ALE_BIT), .CLE_BIT(CLE_BIT)
    ) u_dec (
        .addr(host_addr), .hit(hit), .cs(cs), .phase(phase)
    );

    // Busy gate, accept condition and bus formatting of the write byte/word
    always_comb begin
        exempt     = (host_wdata[7:0] == CMD_RESET) || (host_wdata[7:0] == CMD_STATUS);
        blocked    = host_req && host_wr && hit && (phase == PH_CMD) && !nand_rb_n && !exempt;
        host_ready = !fsm_busy && !blocked;
        accept     = host_req && host_ready;
        mapped_ok  = hit && (phase != PH_NONE) && (host_wr || (phase == PH_DATA));
        fmt_data   = (phase == PH_DATA) ? host_wdata : {{(DW-8){1'b0}}, host_wdata[7:0]};
    end

    ncb_cycle_fsm #(
        .NCS(NCS), .CSW(CSW), .DW(DW),
        .T_SETUP(T_SETUP), .T_ACTIVE(T_ACTIVE), .T_HOLD(T_HOLD)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start(accept && mapped_ok), .start_wr(host_wr), .start_cs(cs),
        .start_phase(phase), .start_data(fmt_data), .dq_in(nand_dq_in),
        .busy(fsm_busy), .ce_n(nand_ce_n), .cle(nand_cle), .ale(nand_ale),
        .we_n(nand_we_n), .re_n(nand_re_n), .dq_out(nand_dq_out),
        .dq_oe(nand_dq_oe), .rd_data(fsm_rd_data), .rd_done(fsm_rd_done)
    );

    // Completion pulse for a read that decodes to no NAND cycle
    always_ff @(posedge clk) begin
        if (!rst_n) quiet_rv <= 1'b0;
        else        quiet_rv <= accept && !mapped_ok && !host_wr;
    end

    // Merge the two read completion sources; silent reads return zero
    always_comb begin
        host_rvalid = fsm_rd_done || quiet_rv;
        host_rdata  = fsm_rd_done ? fsm_rd_data : '0;
    end

    AST_ONE_CE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~nand_ce_n) <= 1); // R2
    AST_BUSY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && host_wr && hit && phase == PH_CMD && !nand_rb_n)
        |-> (host_wdata[7:0] == CMD_RESET || host_wdata[7:0] == CMD_STATUS)); // R7
    AST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !mapped_ok) |=> ((&nand_ce_n) && nand_we_n && nand_re_n)); // R10

endmodule

// File: tb/nand_cycle_bridge_test.sv
// Directed bench: plays the flash side, one task per scenario.
module nand_cycle_bridge_test;
    localparam int TS = 2, TA = 3, TH = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_wr = 1'b0;
    logic [31:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic        host_ready, host_rvalid;
    logic [15:0] host_rdata;
    logic [3:0]  nand_ce_n;
    logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [15:0] nand_dq_out;
    logic [15:0] nand_dq_in = 16'h5A5A;
    logic        nand_rb_n = 1'b1;

    int n_chk = 0, n_bad = 0;

    // flash-side monitor state
    int lat_cnt = 0, pin_act = 0, rv_cnt = 0, gap_err = 0;
    int since_ce = 0, slow = 0, hold_c = 0;
    int last_setup = 0, last_wlow = 0, last_rlow = 0, last_hold = 0;
    logic in_hold = 0, need_gap = 0, prev_we = 1, prev_re = 1;
    logic [3:0]  lat_ce;
    logic        lat_cle, lat_ale, lat_oe;
    logic [15:0] lat_dq, rd_cap;

    nand_cycle_bridge #(.T_SETUP(TS), .T_ACTIVE(TA), .T_HOLD(TH)) uut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
        .host_rvalid(host_rvalid), .host_rdata(host_rdata), .nand_ce_n(nand_ce_n),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
        .nand_dq_in(nand_dq_in), .nand_rb_n(nand_rb_n)
    );

    always #10 clk = ~clk;

    // Flash model: samples pins between edges, latches on write strobe rise
    always @(negedge clk) begin
        if (host_rvalid) begin rv_cnt++; rd_cap = host_rdata; end
        if ((!nand_we_n && prev_we) || (!nand_re_n && prev_re)) begin
            last_setup = since_ce;
            if (need_gap) gap_err++;
            slow = 0;
        end
        if (!nand_we_n || !nand_re_n) slow++;
        if (!nand_re_n) nand_dq_in = 16'hA500 + 16'(slow);
        else            nand_dq_in = 16'h5A5A;
        if ((nand_we_n && !prev_we) || (nand_re_n && !prev_re)) begin
            if (!prev_we) begin
                lat_cnt++; lat_ce = nand_ce_n; lat_cle = nand_cle;
                lat_ale = nand_ale; lat_dq = nand_dq_out; lat_oe = nand_dq_oe;
                last_wlow = slow;
            end else begin
                last_rlow = slow;
            end
            need_gap = 1; in_hold = 1; hold_c = 0;
        end
        if (&nand_ce_n) begin
            if (in_hold) last_hold = hold_c;
            in_hold = 0; need_gap = 0; since_ce = 0;
        end else begin
            since_ce++; pin_act++;
            if (in_hold) hold_c++;
        end
        prev_we = nand_we_n; prev_re = nand_re_n;
    end

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        int t = 0;
        while (!host_ready && t < 200) begin @(negedge clk); t++; end
        check(host_ready, "R5 idle", {31'd0, host_ready}, 1);
    endtask

    task automatic access(input logic wr, input logic [31:0] a, input logic [15:0] d);
        int t = 0;
        @(negedge clk);
        host_req = 1; host_wr = wr; host_addr = a; host_wdata = d;
        while (!host_ready && t < 200) begin @(negedge clk); t++; end
        @(posedge clk);
        @(negedge clk);
        host_req = 0;
        wait_idle();
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        check(nand_ce_n == 4'hF, "R11 ce", {28'd0, nand_ce_n}, 32'hF);
        check(nand_we_n && nand_re_n, "R11 strobes", {30'd0, nand_we_n, nand_re_n}, 3);
        check(!nand_ale && !nand_cle && !nand_dq_oe, "R11 ale/cle/oe",
              {29'd0, nand_ale, nand_cle, nand_dq_oe}, 0);
        check(host_ready && !host_rvalid, "R11 host", {30'd0, host_ready, host_rvalid}, 2);
    endtask

    task automatic t_phases();
        int c0 = lat_cnt;
        access(1, 32'h7000_4000, 16'hBE90);
        check(lat_cle && !lat_ale, "R3 cmd phase", {30'd0, lat_cle, lat_ale}, 2);
        check(lat_dq == 16'h0090, "R4 cmd byte", lat_dq, 16'h0090);
        check(lat_oe, "R4 oe", lat_oe, 1);
        access(1, 32'h7000_2000, 16'hFF3C);
        check(!lat_cle && lat_ale, "R3 addr phase", {30'd0, lat_cle, lat_ale}, 1);
        check(lat_dq == 16'h003C, "R4 addr byte", lat_dq, 16'h003C);
        access(1, 32'h7000_0000, 16'hC3D2);
        check(!lat_cle && !lat_ale, "R3 data phase", {30'd0, lat_cle, lat_ale}, 0);
        check(lat_dq == 16'hC3D2, "R4 data word", lat_dq, 16'hC3D2);
        check(lat_cnt == c0 + 3, "R3 strobe count", lat_cnt, c0 + 3);
        check(last_setup == TS, "R6 setup", last_setup, TS);
        check(last_wlow == TA, "R6 active", last_wlow, TA);
        check(last_hold == TH, "R6 hold", last_hold, TH);
    endtask

    task automatic t_windows();
        for (int n = 0; n < 4; n++) begin
            logic [3:0] e;
            e = ~(4'b1 << n);
            access(1, 32'h7000_4000 | (32'(n) << 26), 16'h0011 + 16'(n));
            check(lat_ce == e, "R1 ce select", {28'd0, lat_ce}, {28'd0, e});
            check($countones(~lat_ce) == 1, "R2 one ce", {28'd0, lat_ce}, {28'd0, e});
        end
    endtask

    task automatic t_read();
        int r0 = rv_cnt;
        access(0, 32'h7400_0000, 16'h0);
        check(rv_cnt == r0 + 1, "R9 one pulse", rv_cnt, r0 + 1);
        check(rd_cap == 16'hA500 + TA, "R9 sample point", rd_cap, 16'hA500 + TA);
        check(last_rlow == TA, "R9 re width", last_rlow, TA);
    endtask

    task automatic t_busy();
        int c0 = lat_cnt, p0 = pin_act;
        nand_rb_n = 0;
        @(negedge clk);
        host_req = 1; host_wr = 1; host_addr = 32'h7800_4000; host_wdata = 16'h0080;
        repeat (10) @(negedge clk);
        check(!host_ready, "R7 held ready", host_ready, 0);
        check(lat_cnt == c0 && pin_act == p0, "R7 no pins", pin_act - p0, 0);
        nand_rb_n = 1;
        @(posedge clk);
        @(negedge clk);
        host_req = 0;
        wait_idle();
        repeat (2) @(negedge clk);
        check(lat_cnt == c0 + 1 && lat_dq == 16'h0080, "R7 released", lat_dq, 16'h0080);
    endtask

    task automatic t_exempt();
        int c0 = lat_cnt;
        nand_rb_n = 0;
        access(1, 32'h7000_4000, 16'h00FF);
        check(lat_cnt == c0 + 1 && lat_dq == 16'h00FF, "R8 reset fwd", lat_dq, 16'h00FF);
        access(1, 32'h7000_4000, 16'h0070);
        check(lat_cnt == c0 + 2 && lat_dq == 16'h0070, "R8 status fwd", lat_dq, 16'h0070);
        nand_rb_n = 1;
    endtask

    task automatic t_unmapped();
        int p0 = pin_act, r0 = rv_cnt;
        access(1, 32'h6000_4000, 16'h0090);
        access(1, 32'h7000_1000, 16'h1234);
        access(1, 32'h7000_6000, 16'h0001);
        check(pin_act == p0, "R10 silent writes", pin_act - p0, 0);
        access(0, 32'h7C00_4000, 16'h0);
        check(rv_cnt == r0 + 1 && rd_cap == 16'h0, "R10 cmd-offset read", rd_cap, 0);
        access(0, 32'h8000_0000, 16'h0);
        check(rv_cnt == r0 + 2 && rd_cap == 16'h0, "R10 outside read", rd_cap, 0);
        check(pin_act == p0, "R10 silent reads", pin_act - p0, 0);
    endtask

    task automatic t_gap();
        access(1, 32'h7000_0000, 16'h1111);
        access(1, 32'h7000_0000, 16'h2222);
        check(gap_err == 0, "R5 ce gap", gap_err, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_phases();
        t_windows();
        t_read();
        t_busy();
        t_exempt();
        t_unmapped();
        t_gap();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule